// File: doc/BRIEF.md
# Bus-Multiplexed Up/Down Binary Counter

A synchronous binary counter, eight bits wide by default, whose load data and whose count readout share one bidirectional bus. For synthesis the bus appears as three signals: an incoming value, an outgoing value and a drive enable. Each rising clock edge performs one operation: clear, load from the bus, hold, or step up or down by one. An active-low master reset clears the count at once, without waiting for the clock.

A combinational active-low terminal-count output marks the last value in the current direction. Wide counters are built by chaining stages, with the terminal count of one stage feeding the trickle enable of the next. All control inputs are active low except the direction input, on which high means count up.

Top module: `busUpDownCounter`

## Requirements
- R1: While rstN (asynchronous master reset) is low, the count is zero without waiting for a clock edge, and every other input is ignored.
- R2: On a rising edge with syncClrN low, the count becomes zero, whatever the load, hold or count inputs are.
- R3: On a rising edge with syncClrN high and both csN and loadN low, the count takes the value on busIn.
- R4: busOe is 1 exactly when csN is low, loadN is high and oeN is low. In that state busOut carries the count. The bus is therefore never driven during a load cycle.
- R5: On a rising edge that neither clears nor loads, a high enPN or a high enTN keeps the count unchanged.
- R6: On a rising edge with both enPN and enTN low and no clear or load, the count rises by one when upDn is 1 and falls by one when upDn is 0. It wraps from 255 to 0 going up and from 0 to 255 going down.
- R7: tcN is low exactly when enTN is low and either the count is all ones with upDn at 1, or the count is zero with upDn at 0. tcN follows upDn and enTN without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rstN | input | 1 | Asynchronous master reset, active low |
| syncClrN | input | 1 | Synchronous clear, active low |
| loadN | input | 1 | Parallel load enable, active low |
| csN | input | 1 | Chip select, active low |
| oeN | input | 1 | Output enable, active low |
| upDn | input | 1 | Direction: 1 counts up, 0 counts down |
| enPN | input | 1 | Parallel count enable, active low |
| enTN | input | 1 | Trickle count enable, active low; also gates tcN |
| busIn | input | WIDTH | Value seen on the shared bus |
| busOut | output | WIDTH | Value driven onto the bus when busOe is 1 |
| busOe | output | 1 | Bus drive enable |
| tcN | output | 1 | Terminal count, active low |

## Verification
Clear, load, hold and count results appear in the count one rising edge after the inputs are applied. The bench drives the inputs, waits for that edge, and reads the count through the bus a quarter period later with the read controls set. busOe, busOut and tcN respond to their inputs without a clock, so those checks sample after a short settling delay with no edge in between. The master reset is checked both while it is held low between edges and when it is released. A bench monitor also flags any load cycle in which the bus is driven, and any cycle in which output enable is asserted while chip select and load are both asserted.

// File: rtl/bus_counter_pkg.sv
package bus_counter_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_LOAD  = 2'd2,
    OP_STEP  = 2'd3
  } cntOp_e;

  typedef struct packed {
    cntOp_e op;
    logic   up;
  } cntCtrl_t;
endpackage

// File: rtl/bus_counter_ctrl.sv
module bus_counter_ctrl
  import bus_counter_pkg::*;
(
  input  logic     syncClrN,
  input  logic     loadN,
  input  logic     csN,
  input  logic     oeN,
  input  logic     upDn,
  input  logic     enPN,
  input  logic     enTN,
  output cntCtrl_t ctrl,
  output logic     driveEn
);
  always_comb begin
    ctrl.up = upDn;
    if (!syncClrN)           ctrl.op = OP_CLEAR;
    else if (!csN && !loadN) ctrl.op = OP_LOAD;
    else if (!enPN && !enTN) ctrl.op = OP_STEP;
    else                     ctrl.op = OP_HOLD;
  end

  assign driveEn = !csN && loadN && !oeN;

  always_comb begin
    // R4
    no_drive_on_load_chk: assert (!(driveEn && ctrl.op == OP_LOAD));
  end
endmodule

// File: rtl/bus_counter_dp.sv
module bus_counter_dp
  import bus_counter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntCtrl_t         ctrl,
  input  logic [WIDTH-1:0] loadVal,
  input  logic             enTN,
  output logic [WIDTH-1:0] count,
  output logic             tcN
);
  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ZERO     = '0;
  localparam logic [WIDTH-1:0] ONE      = WIDTH'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= ZERO;
    else begin
      case (ctrl.op)
        OP_CLEAR: count <= ZERO;
        OP_LOAD:  count <= loadVal;
        OP_STEP:  count <= ctrl.up ? count + ONE : count - ONE;
        default:  count <= count;
      endcase
    end
  end

  assign tcN = !(!enTN && (ctrl.up ? (count == ALL_ONES) : (count == ZERO)));

  // R2
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.op == OP_CLEAR |=> count == ZERO);
  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.op == OP_LOAD |=> count == $past(loadVal));
  // R5
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.op == OP_HOLD |=> $stable(count));
  // R6
  step_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.op == OP_STEP && ctrl.up) |=> count == $past(count) + ONE);
  // R6
  step_dn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.op == OP_STEP && !ctrl.up) |=> count == $past(count) - ONE);
  // R7
  tc_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    enTN |-> tcN);
endmodule

// File: rtl/busUpDownCounter.sv
module busUpDownCounter
  import bus_counter_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             syncClrN,
  input  logic             loadN,
  input  logic             csN,
  input  logic             oeN,
  input  logic             upDn,
  input  logic             enPN,
  input  logic             enTN,
  input  logic [WIDTH-1:0] busIn,
  output logic [WIDTH-1:0] busOut,
  output logic             busOe,
  output logic             tcN
);
  cntCtrl_t         ctrl;
  logic [WIDTH-1:0] count;

  bus_counter_ctrl u_ctrl (
    .syncClrN(syncClrN), .loadN(loadN), .csN(csN), .oeN(oeN),
    .upDn(upDn), .enPN(enPN), .enTN(enTN), .ctrl(ctrl), .driveEn(busOe)
  );

  bus_counter_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .loadVal(busIn),
    .enTN(enTN), .count(count), .tcN(tcN)
  );

  assign busOut = count;

  // R1
  async_clear_chk: assert property (@(posedge clk) !rstN |-> busOut == '0);
endmodule

// File: tb/busUpDownCounter_bench.sv
`timescale 1ns/1ps
module busUpDownCounter_bench;
  logic clk = 0;
  logic rstN = 0, syncClrN = 1, loadN = 1, csN = 1, oeN = 1, upDn = 1, enPN = 1, enTN = 1;
  logic [7:0] busIn = '0;
  logic [7:0] busOut;
  logic busOe, tcN;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  busUpDownCounter u_busUpDownCounter (.*);

  always @(posedge clk) begin
    if (rstN && busOe && !loadN && !csN && syncClrN) begin
      errors++; $display("FAIL R4 bus driven during load act=1 exp=0");
    end
    if (rstN && !oeN && !csN && !loadN)
      $display("usage warning: output enable active during load cycle");
  end

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++; $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Idle controls, then a rising edge, then a readback through the bus.
  task automatic idle();
    syncClrN = 1; loadN = 1; csN = 1; oeN = 1; enPN = 1; enTN = 1;
  endtask

  task automatic readCount(output logic [7:0] v);
    idle(); csN = 0; oeN = 0; #0.5; v = busOut;
  endtask

  task automatic stepEdge();
    @(posedge clk); #1.25;
  endtask

  task automatic loadVal(logic [7:0] v);
    @(negedge clk); idle(); csN = 0; loadN = 0; busIn = v; stepEdge();
  endtask

  task automatic testReset();
    logic [7:0] v;
    #0.5; chk("R1", u_busUpDownCounter.busOut, 8'h00);
    @(negedge clk); rstN = 1;
    loadVal(8'h5A);
    @(negedge clk); rstN = 0; #0.5;
    readCount(v); chk("R1", v, 8'h00);
    csN = 0; loadN = 0; busIn = 8'hFF; stepEdge();
    readCount(v); chk("R1", v, 8'h00);
    @(negedge clk); rstN = 1;
  endtask

  task automatic testLoadBus();
    logic [7:0] v;
    loadVal(8'hC3); readCount(v); chk("R3", v, 8'hC3);
    chk("R4", busOe, 1); 
    oeN = 1; #0.5; chk("R4", busOe, 0);
    oeN = 0; loadN = 0; #0.5; chk("R4", busOe, 0);
    loadN = 1; csN = 1; #0.5; chk("R4", busOe, 0);
  endtask

  task automatic testClear();
    logic [7:0] v;
    loadVal(8'h77);
    @(negedge clk); idle(); syncClrN = 0; csN = 0; loadN = 0; busIn = 8'h11;
    enPN = 0; enTN = 0; stepEdge();
    readCount(v); chk("R2", v, 8'h00);
  endtask

  task automatic testHold();
    logic [7:0] v;
    loadVal(8'h40);
    @(negedge clk); idle(); enPN = 1; enTN = 0; stepEdge();
    readCount(v); chk("R5", v, 8'h40);
    @(negedge clk); idle(); enPN = 0; enTN = 1; stepEdge();
    readCount(v); chk("R5", v, 8'h40);
    @(negedge clk); idle(); loadN = 0; busIn = 8'h99; enPN = 1; stepEdge();
    readCount(v); chk("R5", v, 8'h40);
  endtask

  task automatic testCount();
    logic [7:0] v;
    loadVal(8'hFE);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); idle(); enPN = 0; enTN = 0; upDn = 1; stepEdge();
    end
    readCount(v); chk("R6", v, 8'h01);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk); idle(); enPN = 0; enTN = 0; upDn = 0; stepEdge();
    end
    readCount(v); chk("R6", v, 8'hFF);
  endtask

  task automatic testTc();
    loadVal(8'hFF);
    @(negedge clk); idle(); upDn = 1; enTN = 0; #0.5; chk("R7", tcN, 0);
    upDn = 0; #0.5; chk("R7", tcN, 1);
    upDn = 1; enTN = 1; #0.5; chk("R7", tcN, 1);
    loadVal(8'h00);
    @(negedge clk); idle(); upDn = 0; enTN = 0; #0.5; chk("R7", tcN, 0);
    upDn = 1; #0.5; chk("R7", tcN, 1);
    loadVal(8'h80);
    @(negedge clk); idle(); upDn = 0; enTN = 0; #0.5; chk("R7", tcN, 1);
  endtask

  initial begin
    testReset();
    testLoadBus();
    testClear();
    testHold();
    testCount();
    testTc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=running exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule